// File: doc/BRIEF.md
# ADC Conversion Sequencer with Result Memory

This block is the digital side of an analog-to-digital converter. It holds a table of 32 channel-control entries and 32 result registers. Software fills the entries over a simple register bus, picks a conversion mode, a start index, a resolution and a result format, and sets an enable bit. The sequencer then asks the converter core for one conversion at a time, using a request/done handshake. With each request it presents the channel and the differential setting of the current entry.

A hidden pointer selects the current entry. The single modes use only the entry at the start index. The sequence modes walk forward from the start index. The pointer wraps from the last entry to entry 0, and the walk stops after an entry marked end-of-sequence. The repeating modes keep converting until software clears the enable bit.

Each raw result is reformatted in one of two ways: right-justified unsigned, or left-justified two's complement. The reformatted value is written to the result register of the same index, and that entry's flag is raised. Software clears a flag either by writing one to it or by reading the matching result.

Top module: `adc_seq_ctrl`

Register map (7-bit word address, 16-bit data):
- 0x00+n is control entry n. Bits [4:0] select the channel, bit 5 marks the entry differential, bit 6 marks end-of-sequence, and bits [8:7] hold a reference selection that is only stored.
- 0x20+n is result n. It is read-only, and a read clears flag n.
- 0x40 is the configuration register. Bits [1:0] set the mode: 00 single, 01 sequence, 10 repeat-single, 11 repeat-sequence. Bits [6:2] hold the start index. Bits [8:7] set the resolution: 00 is 8-bit, 01 is 10-bit, 10 or 11 is 12-bit. Bit 9 selects the format, 1 for left-justified. Bit 10 is the enable.
- 0x41 holds flags 0 to 15 and 0x42 holds flags 16 to 31. Both are write-one-to-clear.

## Requirements
- R1: A control entry reads back what was written in bits [8:0]; bits [15:9] read as zero.
- R2: In single mode (00), the entry at the start index is converted exactly once. After that conversion the request drops and the enable bit (bit 10 of 0x40) reads 0.
- R3: In sequence mode (01), conversions start at the start-index entry and advance by one entry per completed conversion. Each request presents the current entry's channel. The mode stops after converting an entry whose bit 6 is set.
- R4: In the sequence modes, the entry after entry 31 is entry 0 whenever entry 31 has no end-of-sequence bit.
- R5: In repeat-single mode (10), the start-index entry is converted again and again. Once enable is cleared, the conversion in progress finishes and no further request is issued.
- R6: In repeat-sequence mode (11), the pointer reloads the start index after the end-of-sequence entry.
- R7: Completing a conversion of entry n writes result n and sets flag n. Flag n is bit n mod 16 of word 0x41 (n < 16) or word 0x42 (n >= 16).
- R8: With format bit 0 and a single-ended entry, the result is the low 8, 10 or 12 converter bits, zero-extended. Converter bits above the resolution are ignored.
- R9: With format bit 0 and a differential entry, the signed converter value is offset to unsigned by adding 128, 512 or 2048 (modulo the resolution).
- R10: With format bit 1, the result is two's complement, left-justified in 16 bits, with the low 8, 6 or 4 bits zero. A single-ended code is mapped to signed by subtracting half of full scale.
- R11: Writing a one to a flag bit, or reading result n, clears the matching flag and leaves all other flags unchanged.
- R12: If a flag is set by a completion and cleared (by either method) in the same cycle, the flag ends up set.
- R13: After reset the request is low, and the configuration, all flags, all entries and all results read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (used for read-to-clear) |
| bus_addr_i | input | 7 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_ch_o | output | 5 | Channel of the current entry |
| conv_diff_o | output | 1 | Differential setting of the current entry |
| conv_res_o | output | 2 | Resolution code for the converter |
| conv_done_i | input | 1 | One-cycle completion pulse from the converter |
| conv_data_i | input | 12 | Raw result, valid with conv_done_i |

## Verification
Two things can hit the same interrupt flag in the same clock edge: a completion that sets it, and a software clear, either a write-one-to-clear or a read of the result register. The bench's converter model makes the done pulse, so the bench knows the exact cycle in which done is presented. In that same cycle it drives the clearing bus access, once as a write to the flag word and once as a read of the result. Each time it then reads the flag word back and expects the flag to be set, and it compares this with a plain clear outside the collision, which must leave the flag at 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned NUM_ENTRIES = 32;
  localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES);
  localparam int unsigned CH_W        = 5;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned RAW_W       = 12;
  localparam int unsigned ADDR_W      = IDX_W + 2;
  localparam int unsigned FLAG_WORDS  = NUM_ENTRIES / DATA_W;

  typedef enum logic [1:0] {
    MODE_SINGLE     = 2'b00,
    MODE_SEQ        = 2'b01,
    MODE_RPT_SINGLE = 2'b10,
    MODE_RPT_SEQ    = 2'b11
  } mode_e;

  typedef struct packed {
    logic [1:0]      vref;
    logic            eos;
    logic            diff;
    logic [CH_W-1:0] chan;
  } entry_t;

  typedef struct packed {
    logic             en;
    logic             left_fmt;
    logic [1:0]       res;
    logic [IDX_W-1:0] start;
    mode_e            mode;
  } cfg_t;

  localparam int unsigned ENTRY_W = $bits(entry_t);
  localparam int unsigned CFG_W   = $bits(cfg_t);

  function automatic int unsigned res_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 10;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        entry_we_i,
  input  logic [IDX_W-1:0]            entry_idx_i,
  input  entry_t                      entry_wdata_i,
  input  logic                        cfg_we_i,
  input  cfg_t                        cfg_wdata_i,
  input  logic                        stop_i,
  output entry_t [NUM_ENTRIES-1:0]    entries_o,
  output cfg_t                        cfg_o
);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      entries_o[g] <= '0;
      else if (entry_we_i && entry_idx_i == IDX_W'(g)) entries_o[g] <= entry_wdata_i;
    end
  end

  // bus write wins over the sequencer's self-clear of enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cfg_o <= '0;
    else if (cfg_we_i)  cfg_o <= cfg_wdata_i;
    else if (stop_i)    cfg_o.en <= 1'b0;
  end

  assert_stop_clears_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !cfg_we_i |=> !cfg_o.en);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  cfg_t                   cfg_i,
  input  logic [NUM_ENTRIES-1:0] eos_i,
  input  logic                   done_i,
  output logic                   busy_o,
  output logic [IDX_W-1:0]       ptr_o,
  output logic                   wr_o,
  output logic                   stop_o
);

  typedef enum logic {ST_IDLE, ST_BUSY} st_e;
  st_e              state_q;
  logic             cont;
  logic [IDX_W-1:0] nxt_ptr;
  logic             cur_eos;

  assign cur_eos = eos_i[ptr_o];

  always_comb begin
    cont    = 1'b0;
    nxt_ptr = ptr_o;
    case (cfg_i.mode)
      MODE_SINGLE:     cont = 1'b0;
      MODE_RPT_SINGLE: cont = cfg_i.en;
      MODE_SEQ: begin
        cont    = cfg_i.en && !cur_eos;
        nxt_ptr = ptr_o + 1'b1;                 // natural wrap at the top entry
      end
      default: begin
        cont    = cfg_i.en;
        nxt_ptr = cur_eos ? cfg_i.start : ptr_o + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_o   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cfg_i.en) begin
          state_q <= ST_BUSY;
          ptr_o   <= cfg_i.start;
        end
        default: if (done_i) begin
          if (cont) ptr_o   <= nxt_ptr;
          else      state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o = (state_q == ST_BUSY);
  assign wr_o   = busy_o && done_i;
  assign stop_o = wr_o && !cont;

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_i |=> busy_o && $stable(ptr_o));

  assert_single_stop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o && cfg_i.mode == MODE_SINGLE |=> !busy_o);

  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o && cfg_i.mode == MODE_SEQ && cfg_i.en && !cur_eos
    && ptr_o == IDX_W'(NUM_ENTRIES-1) |=> busy_o && ptr_o == '0);

  assert_rpt_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o && cfg_i.mode == MODE_RPT_SINGLE && cfg_i.en |=> busy_o && ptr_o == $past(ptr_o));

  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o && cfg_i.mode == MODE_RPT_SEQ && cfg_i.en && cur_eos |=> ptr_o == $past(cfg_i.start));

endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt
  import adc_seq_pkg::*;
#(
  parameter int unsigned IN_W  = RAW_W,
  parameter int unsigned OUT_W = DATA_W
) (
  input  logic [IN_W-1:0]  raw_i,
  input  logic [1:0]       res_i,
  input  logic             left_i,
  input  logic             diff_i,
  output logic [OUT_W-1:0] data_o
);

  int unsigned      nb;
  logic [IN_W-1:0]  mask, msb, v, uns, sgn;

  // flipping the top bit of an n-bit code equals adding/subtracting 2^(n-1) mod 2^n
  always_comb begin
    nb     = res_bits(res_i);
    mask   = ~({IN_W{1'b1}} << nb);
    msb    = {{(IN_W-1){1'b0}}, 1'b1} << (nb - 1);
    v      = raw_i & mask;
    uns    = diff_i ? (v ^ msb) : v;
    sgn    = diff_i ? v : (v ^ msb);
    data_o = left_i ? (OUT_W'(sgn) << (OUT_W - nb)) : OUT_W'(uns);
  end

endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results
  import adc_seq_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_i,
  input  logic [IDX_W-1:0]                    wr_idx_i,
  input  logic [DATA_W-1:0]                   wr_data_i,
  input  logic [NUM_ENTRIES-1:0]              clr_i,
  output logic [NUM_ENTRIES-1:0][DATA_W-1:0]  mem_o,
  output logic [NUM_ENTRIES-1:0]              flags_o
);

  logic [NUM_ENTRIES-1:0] set;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    assign set[g] = wr_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_o[g]   <= '0;
        flags_o[g] <= 1'b0;
      end else begin
        if (set[g]) mem_o[g] <= wr_data_i;
        if (set[g])        flags_o[g] <= 1'b1;   // set beats clear
        else if (clr_i[g]) flags_o[g] <= 1'b0;
      end
    end
  end

  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> flags_o[$past(wr_idx_i)] && mem_o[$past(wr_idx_i)] == $past(wr_data_i));

  assert_set_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && clr_i[wr_idx_i] |=> flags_o[$past(wr_idx_i)]);

  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i & ~set) != '0 |=> (flags_o & $past(clr_i & ~set)) == '0);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_ch_o,
  output logic              conv_diff_o,
  output logic [1:0]        conv_res_o,
  input  logic              conv_done_i,
  input  logic [RAW_W-1:0]  conv_data_i
);

  localparam logic [1:0] RG_ENTRY = 2'd0;
  localparam logic [1:0] RG_RES   = 2'd1;
  localparam logic [1:0] RG_MISC  = 2'd2;

  logic [1:0]       region;
  logic [IDX_W-1:0] idx;
  assign region = bus_addr_i[ADDR_W-1:IDX_W];
  assign idx    = bus_addr_i[IDX_W-1:0];

  entry_t [NUM_ENTRIES-1:0]             entries;
  cfg_t                                 cfg;
  logic [NUM_ENTRIES-1:0]               eos_vec;
  logic [NUM_ENTRIES-1:0][DATA_W-1:0]   mem;
  logic [NUM_ENTRIES-1:0]               flags;
  logic [NUM_ENTRIES-1:0]               clr;
  logic                                 busy, wr, stop;
  logic [IDX_W-1:0]                     ptr;
  logic [DATA_W-1:0]                    fmt_data;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_eos
    assign eos_vec[g] = entries[g].eos;
  end

  adc_seq_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .entry_we_i    (bus_we_i && region == RG_ENTRY),
    .entry_idx_i   (idx),
    .entry_wdata_i (entry_t'(bus_wdata_i[ENTRY_W-1:0])),
    .cfg_we_i      (bus_we_i && region == RG_MISC && idx == '0),
    .cfg_wdata_i   (cfg_t'(bus_wdata_i[CFG_W-1:0])),
    .stop_i        (stop),
    .entries_o     (entries),
    .cfg_o         (cfg)
  );

  adc_seq_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg),
    .eos_i  (eos_vec),
    .done_i (conv_done_i),
    .busy_o (busy),
    .ptr_o  (ptr),
    .wr_o   (wr),
    .stop_o (stop)
  );

  adc_seq_fmt u_fmt (
    .raw_i  (conv_data_i),
    .res_i  (cfg.res),
    .left_i (cfg.left_fmt),
    .diff_i (entries[ptr].diff),
    .data_o (fmt_data)
  );

  always_comb begin
    clr = '0;
    if (bus_re_i && region == RG_RES) clr[idx] = 1'b1;
    for (int w = 0; w < FLAG_WORDS; w++) begin
      if (bus_we_i && region == RG_MISC && idx == IDX_W'(w + 1))
        clr[w*DATA_W +: DATA_W] = bus_wdata_i;
    end
  end

  adc_seq_results u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wr_idx_i  (ptr),
    .wr_data_i (fmt_data),
    .clr_i     (clr),
    .mem_o     (mem),
    .flags_o   (flags)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (region)
      RG_ENTRY: bus_rdata_o = DATA_W'(entries[idx]);
      RG_RES:   bus_rdata_o = mem[idx];
      RG_MISC: begin
        if (idx == '0) bus_rdata_o = DATA_W'(cfg);
        for (int w = 0; w < FLAG_WORDS; w++)
          if (idx == IDX_W'(w + 1)) bus_rdata_o = flags[w*DATA_W +: DATA_W];
      end
      default: bus_rdata_o = '0;
    endcase
  end

  assign conv_req_o  = busy;
  assign conv_ch_o   = entries[ptr].chan;
  assign conv_diff_o = entries[ptr].diff;
  assign conv_res_o  = cfg.res;

  assert_rj_top_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !cfg.left_fmt && cfg.res == 2'b00 |-> fmt_data[DATA_W-1:8] == '0);

  assert_lj_low_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && cfg.left_fmt && cfg.res == 2'b00 |-> fmt_data[7:0] == '0);

  assert_idle_no_req_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_req_o && !cfg.en |=> !conv_req_o);

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  import adc_seq_pkg::*;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              bus_we, bus_re;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic              conv_req, conv_diff, conv_done;
  logic [CH_W-1:0]   conv_ch;
  logic [1:0]        conv_res;
  logic [RAW_W-1:0]  conv_data;

  always #5 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_we_i(bus_we), .bus_re_i(bus_re), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .conv_req_o(conv_req), .conv_ch_o(conv_ch), .conv_diff_o(conv_diff),
    .conv_res_o(conv_res), .conv_done_i(conv_done), .conv_data_i(conv_data)
  );

  int n_chk = 0, n_fail = 0;
  int n_conv = 0;
  int wait_cnt = 0;
  logic [CH_W-1:0] ch_log [256];
  bit              use_fixed = 1'b0;
  logic [RAW_W-1:0] raw_fixed = '0;

  localparam logic [ADDR_W-1:0] A_CFG = 7'h40;
  localparam logic [ADDR_W-1:0] A_FLO = 7'h41;
  localparam logic [ADDR_W-1:0] A_FHI = 7'h42;

  typedef struct packed {
    logic [1:0]  res;
    logic        left;
    logic        diff;
    logic [11:0] raw;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{2'b10, 1'b0, 1'b0, 12'hABC, 16'h0ABC},
    '{2'b10, 1'b0, 1'b0, 12'hFFF, 16'h0FFF},
    '{2'b00, 1'b0, 1'b0, 12'hFFF, 16'h00FF},
    '{2'b01, 1'b0, 1'b0, 12'h3FF, 16'h03FF},
    '{2'b10, 1'b0, 1'b1, 12'h800, 16'h0000},
    '{2'b10, 1'b0, 1'b1, 12'h7FF, 16'h0FFF},
    '{2'b00, 1'b0, 1'b1, 12'h000, 16'h0080},
    '{2'b01, 1'b0, 1'b1, 12'h3FF, 16'h01FF},
    '{2'b10, 1'b1, 1'b0, 12'h000, 16'h8000},
    '{2'b10, 1'b1, 1'b0, 12'hFFF, 16'h7FF0},
    '{2'b00, 1'b1, 1'b0, 12'h0FF, 16'h7F00},
    '{2'b01, 1'b1, 1'b0, 12'h000, 16'h8000},
    '{2'b10, 1'b1, 1'b1, 12'h800, 16'h8000},
    '{2'b01, 1'b1, 1'b1, 12'h1FF, 16'h7FC0},
    '{2'b00, 1'b1, 1'b1, 12'h080, 16'h8000},
    '{2'b10, 1'b1, 1'b1, 12'h001, 16'h0010}
  };

  // converter model: answers every request after three cycles
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (rst_ni === 1'b1 && conv_req === 1'b1) begin
        wait_cnt++;
        if (wait_cnt == 3) begin
          wait_cnt  = 0;
          conv_done = 1'b1;
          conv_data = use_fixed ? raw_fixed : RAW_W'(conv_ch);
          if (n_conv < 256) ch_log[n_conv] = conv_ch;
          n_conv++;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    @(negedge clk);
    while (conv_req) @(negedge clk);
  endtask

  task automatic wait_done_edge();
    do begin
      @(negedge clk);
      #1;
    end while (conv_done !== 1'b1);
  endtask

  function automatic logic [DATA_W-1:0] cfgw(bit en, bit left, logic [1:0] res,
                                             logic [4:0] st, logic [1:0] mode);
    return {5'b0, en, left, res, st, mode};
  endfunction

  function automatic logic [DATA_W-1:0] entw(logic [4:0] ch, bit diff, bit eos);
    return {9'b0, eos, diff, ch};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    int base, c1, bad;
    rst_ni = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R13 reset state
    check("R13", "req", 32'(conv_req), 32'd0);
    bus_read(A_CFG, d);  check("R13", "cfg", 32'(d), 32'd0);
    bus_read(A_FLO, d);  check("R13", "flags lo", 32'(d), 32'd0);
    bus_read(A_FHI, d);  check("R13", "flags hi", 32'(d), 32'd0);
    bus_read(7'h05, d);  check("R13", "entry", 32'(d), 32'd0);
    bus_read(7'h25, d);  check("R13", "result", 32'(d), 32'd0);

    // R1 entry storage
    bus_write(7'h05, 16'h01E5);
    bus_read(7'h05, d);  check("R1", "entry rb", 32'(d), 32'h01E5);
    bus_write(7'h05, 16'hFFFF);
    bus_read(7'h05, d);  check("R1", "entry upper", 32'(d), 32'h01FF);

    // formatter table (R8 R9 R10) through entry 0
    use_fixed = 1'b1;
    for (int i = 0; i < 16; i++) begin
      bus_write(7'h00, entw(5'd3, VECS[i].diff, 1'b0));
      raw_fixed = VECS[i].raw;
      bus_write(A_CFG, cfgw(1'b1, VECS[i].left, VECS[i].res, 5'd0, MODE_SINGLE));
      wait_idle();
      if (i == 0) begin
        bus_read(A_FLO, d); check("R7", "flag0 set", 32'(d[0]), 32'd1);
      end
      bus_read(7'h20, d);
      if (VECS[i].left)      check("R10", $sformatf("vec %0d", i), 32'(d), 32'(VECS[i].exp));
      else if (VECS[i].diff) check("R9",  $sformatf("vec %0d", i), 32'(d), 32'(VECS[i].exp));
      else                   check("R8",  $sformatf("vec %0d", i), 32'(d), 32'(VECS[i].exp));
      if (i == 0) begin
        bus_read(A_FLO, d); check("R11", "read clears flag0", 32'(d[0]), 32'd0);
      end
    end
    use_fixed = 1'b0;
    bus_write(7'h00, entw(5'd31, 1'b0, 1'b0));

    // R2 single mode
    bus_write(7'h09, entw(5'd22, 1'b0, 1'b0));
    base = n_conv;
    bus_write(A_CFG, cfgw(1'b1, 1'b0, 2'b10, 5'd9, MODE_SINGLE));
    wait_idle();
    repeat (10) @(negedge clk);
    check("R2", "count", 32'(n_conv - base), 32'd1);
    check("R2", "channel", 32'(ch_log[base]), 32'd22);
    check("R2", "req low", 32'(conv_req), 32'd0);
    bus_read(A_CFG, d); check("R2", "enable cleared", 32'(d[10]), 32'd0);

    // R3 sequence mode, entries 3..6, eos on 6
    bus_write(A_FLO, 16'hFFFF); bus_write(A_FHI, 16'hFFFF);
    for (int e = 3; e <= 6; e++) bus_write(ADDR_W'(e), entw(5'(31 - e), 1'b0, e == 6));
    base = n_conv;
    bus_write(A_CFG, cfgw(1'b1, 1'b0, 2'b10, 5'd3, MODE_SEQ));
    wait_idle();
    repeat (10) @(negedge clk);
    check("R3", "count", 32'(n_conv - base), 32'd4);
    bad = 0;
    for (int k = 0; k < 4; k++) if (ch_log[base + k] !== 5'(28 - k)) bad++;
    check("R3", "channel order", 32'(bad), 32'd0);
    bus_read(A_FLO, d); check("R7", "seq flags", 32'(d), 32'h0078);
    bus_read(7'h24, d); check("R7", "result 4", 32'(d), 32'd27);

    // R4 wrap 30,31,0,1
    bus_write(A_FLO, 16'hFFFF); bus_write(A_FHI, 16'hFFFF);
    bus_write(7'h1E, entw(5'd1,  1'b0, 1'b0));
    bus_write(7'h1F, entw(5'd0,  1'b0, 1'b0));
    bus_write(7'h00, entw(5'd31, 1'b0, 1'b0));
    bus_write(7'h01, entw(5'd30, 1'b0, 1'b1));
    base = n_conv;
    bus_write(A_CFG, cfgw(1'b1, 1'b0, 2'b10, 5'd30, MODE_SEQ));
    wait_idle();
    check("R4", "count", 32'(n_conv - base), 32'd4);
    bad = 0;
    if (ch_log[base] !== 5'd1)   bad++;
    if (ch_log[base+1] !== 5'd0) bad++;
    if (ch_log[base+2] !== 5'd31) bad++;
    if (ch_log[base+3] !== 5'd30) bad++;
    check("R4", "wrap order", 32'(bad), 32'd0);
    bus_read(A_FHI, d); check("R4", "flags hi", 32'(d), 32'hC000);
    bus_read(A_FLO, d); check("R4", "flags lo", 32'(d), 32'h0003);

    // R5 repeat single
    bus_write(7'h0C, entw(5'd19, 1'b0, 1'b0));
    base = n_conv;
    bus_write(A_CFG, cfgw(1'b1, 1'b0, 2'b10, 5'd12, MODE_RPT_SINGLE));
    while (n_conv < base + 3) @(negedge clk);
    bus_write(A_CFG, cfgw(1'b0, 1'b0, 2'b10, 5'd12, MODE_RPT_SINGLE));
    wait_idle();
    c1 = n_conv;
    repeat (20) @(negedge clk);
    check("R5", "stopped", 32'(n_conv - c1), 32'd0);
    check("R5", "req low", 32'(conv_req), 32'd0);
    bad = 0;
    for (int k = base; k < c1; k++) if (ch_log[k] !== 5'd19) bad++;
    check("R5", "same entry", 32'(bad), 32'd0);

    // R6 repeat sequence 20,21
    bus_write(7'h14, entw(5'd11, 1'b0, 1'b0));
    bus_write(7'h15, entw(5'd10, 1'b0, 1'b1));
    base = n_conv;
    bus_write(A_CFG, cfgw(1'b1, 1'b0, 2'b10, 5'd20, MODE_RPT_SEQ));
    while (n_conv < base + 5) @(negedge clk);
    bus_write(A_CFG, cfgw(1'b0, 1'b0, 2'b10, 5'd20, MODE_RPT_SEQ));
    wait_idle();
    bad = 0;
    for (int k = 0; k < 5; k++) if (ch_log[base + k] !== ((k % 2 == 0) ? 5'd11 : 5'd10)) bad++;
    check("R6", "reload order", 32'(bad), 32'd0);

    // R11 w1c clears one flag only
    bus_write(A_FLO, 16'hFFFF); bus_write(A_FHI, 16'hFFFF);
    bus_write(7'h02, entw(5'd4, 1'b0, 1'b0));
    bus_write(A_CFG, cfgw(1'b1, 1'b0, 2'b10, 5'd2, MODE_SINGLE));
    wait_idle();
    bus_write(A_CFG, cfgw(1'b1, 1'b0, 2'b10, 5'd3, MODE_SINGLE));
    wait_idle();
    bus_write(A_FLO, 16'h0004);
    bus_read(A_FLO, d); check("R11", "w1c one flag", 32'(d), 32'h0008);

    // R12 set and w1c in the same cycle
    bus_write(A_FLO, 16'hFFFF);
    bus_write(7'h07, entw(5'd5, 1'b0, 1'b0));
    bus_write(A_CFG, cfgw(1'b1, 1'b0, 2'b10, 5'd7, MODE_SINGLE));
    wait_done_edge();
    bus_we = 1'b1; bus_addr = A_FLO; bus_wdata = 16'h0080;
    @(negedge clk);
    bus_we = 1'b0;
    wait_idle();
    bus_read(A_FLO, d); check("R12", "set over w1c", 32'(d[7]), 32'd1);

    // R12 set and read-clear in the same cycle
    bus_write(A_FLO, 16'hFFFF);
    bus_read(A_FLO, d); check("R11", "w1c all", 32'(d), 32'd0);
    bus_write(A_CFG, cfgw(1'b1, 1'b0, 2'b10, 5'd7, MODE_SINGLE));
    wait_done_edge();
    bus_re = 1'b1; bus_addr = 7'h27;
    @(negedge clk);
    bus_re = 1'b0;
    wait_idle();
    bus_read(A_FLO, d); check("R12", "set over read-clear", 32'(d[7]), 32'd1);
    bus_read(7'h27, d); check("R7", "result 7", 32'(d), 32'd5);
    bus_read(A_FLO, d); check("R11", "read clears flag7", 32'(d[7]), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule